// File: doc/BRIEF.md
# At-Speed Scan Capture Sequencer

This block paces the test clock and the scan-enable control of mux-D scan chains from one fast on-chip clock. Every scan clock pulse leaves the block as a one-fast-cycle enable for an external glitch-free clock gate. Shift pulses are spread out by a programmable divider, so the chains load and unload at a slow rate. Around each capture the block can place a single back-to-back pair of enables, which gives the one at-speed launch-to-capture interval a delay test needs.

A run begins with a start request while the block is idle. It loads the first pattern and then, for each pattern, applies the capture pulses. Each capture is followed by one shift phase of chain length that unloads the response and loads the next pattern at the same time. Three capture styles are supported. In the static style, scan enable drops for one slow capture pulse. In the shift-launch style, the final shift pulse launches the transition and the capture follows on the next fast cycle. In the capture-launch style, scan enable drops early, and two capture pulses follow, of which only the second comes at speed. An equal-rate setting slows the at-speed interval down to the shift rate. Scan enable is produced through a retiming register so that it can be distributed as a timing-critical net.

Top module: `atspeed_capture_seq`

## Requirements
- R1: While reset is held and after it, with no start, scan_clk_en, done, load_active, capture_active and unload_active are 0 and scan_en is 1.
- R2: With chain length N and pattern count P, a run emits N shift pulses, then, P times, C capture pulses followed by N shift pulses. C is 2 when capture_mode is 2'b10 and 1 for 2'b00, 2'b01 and 2'b11.
- R3: Consecutive pulses of a run are exactly D fast cycles apart, where D is the programmed divider. The only exceptions are the at-speed intervals of R4 and R5, which are 1 cycle, and there is at most one of them per pattern.
- R4: With capture_mode 2'b01 and equal_rate 0, the capture pulse comes 1 cycle after the last shift of a phase. scan_en is 1 in the cycle before that capture pulse and 0 during it.
- R5: With capture_mode 2'b10 and equal_rate 0, the first capture comes D cycles after the last shift and the second comes 1 cycle after the first. scan_en is 0 in the cycle before each of them.
- R6: With capture_mode 2'b00 or 2'b11, the single capture comes D cycles after the last shift and a run has no interval shorter than D.
- R7: scan_en is 1 at every shift pulse and 0 at every capture pulse. It is 0 in the fast cycle after each shift pulse that precedes a capture, and it is 1 again in the cycle after the last capture pulse of a pattern.
- R8: With equal_rate 1, every interval of the run is D cycles in all modes, while the scan_en levels of R7 still hold.
- R9: The status flags change together with each pulse and describe it. A shift pulse of the first load has only load_active set. A shift pulse between captures has load_active and unload_active set. A shift pulse of the final phase has only unload_active set. A capture pulse has only capture_active set.
- R10: done is 1 for exactly one fast cycle, the cycle after the last pulse. In that cycle all flags are 0 and scan_en is 1.
- R11: capture_mode, equal_rate, chain_len, shift_div and pattern_count are sampled only on a start seen while idle. A start or configuration change during a run has no effect on that run.
- R12: A divider below 2 acts as 2, a chain length of 0 acts as 1, and a pattern count of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock (stands in for the PLL output) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; honoured only while idle |
| capture_mode | input | 2 | 00 static, 01 shift-launch, 10 capture-launch, 11 treated as static |
| equal_rate | input | 1 | 1: at-speed interval slowed to the shift rate |
| chain_len | input | 16 | Shift pulses per shift phase |
| shift_div | input | 8 | Fast cycles between slow pulses |
| pattern_count | input | 16 | Patterns per run |
| scan_clk_en | output | 1 | One-cycle enable for the scan clock gate |
| scan_en | output | 1 | Retimed scan enable (1 = shift) |
| load_active | output | 1 | Current pulse loads a pattern |
| capture_active | output | 1 | Current pulse is a capture |
| unload_active | output | 1 | Current pulse unloads a response |
| done | output | 1 | One-cycle pulse after the last pulse of a run |

## Verification
The assertions assume that reset is applied from time zero. They also assume that configuration takes effect only through start, so any run seen on the outputs is a single, uninterrupted sequence. The stimulus keeps every programmed divider at 2 or more after clamping, so a 1-cycle gap always means the at-speed pair. The bench sweeps all four mode codes, both rate settings, several chain lengths, dividers and pattern counts, plus the clamp values. It predicts each pulse's interval, scan-enable level and flags from its index alone. In one run it issues a second start with a different configuration, to show that the run in progress keeps its sampled settings.

// File: rtl/acs_pkg.sv
package acs_pkg;

    parameter int ACS_LEN_W = 16;
    parameter int ACS_DIV_W = 8;
    parameter int ACS_PAT_W = 16;
    localparam int ACS_MIN_DIV = 2;

    typedef enum logic [1:0] {
        MODE_STATIC         = 2'b00,
        MODE_SHIFT_LAUNCH   = 2'b01,
        MODE_CAPTURE_LAUNCH = 2'b10,
        MODE_SPARE          = 2'b11
    } acs_mode_e;

    typedef enum logic [1:0] {
        PULSE_SHIFT      = 2'd0,
        PULSE_CAP_FIRST  = 2'd1,
        PULSE_CAP_SECOND = 2'd2
    } acs_pulse_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } acs_state_e;

    typedef struct packed {
        acs_mode_e              mode;
        logic                   equal_rate;
        logic [ACS_LEN_W-1:0]   len;
        logic [ACS_DIV_W-1:0]   div;
    } acs_cfg_t;

    typedef struct packed {
        logic load;
        logic capture;
        logic unload;
    } acs_flags_t;

    function automatic logic [ACS_DIV_W-1:0] clamp_div(input logic [ACS_DIV_W-1:0] d);
        return (d < ACS_DIV_W'(ACS_MIN_DIV)) ? ACS_DIV_W'(ACS_MIN_DIV) : d;
    endfunction

    function automatic logic [ACS_LEN_W-1:0] clamp_len(input logic [ACS_LEN_W-1:0] n);
        return (n == '0) ? ACS_LEN_W'(1) : n;
    endfunction

    function automatic logic [ACS_PAT_W-1:0] clamp_pats(input logic [ACS_PAT_W-1:0] p);
        return (p == '0) ? ACS_PAT_W'(1) : p;
    endfunction

    function automatic logic two_captures(input acs_cfg_t c);
        return c.mode == MODE_CAPTURE_LAUNCH;
    endfunction

    function automatic logic fast_launch(input acs_cfg_t c);
        return (c.mode == MODE_SHIFT_LAUNCH) && !c.equal_rate;
    endfunction

endpackage

// File: rtl/acs_cfg_latch.sv
module acs_cfg_latch
    import acs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic [1:0]           mode_in,
    input  logic                 equal_in,
    input  logic [ACS_LEN_W-1:0] len_in,
    input  logic [ACS_DIV_W-1:0] div_in,
    output acs_cfg_t             cfg_q
);

    acs_cfg_t cfg_d;

    always_comb begin
        cfg_d            = cfg_q;
        if (take) begin
            cfg_d.mode       = acs_mode_e'(mode_in);
            cfg_d.equal_rate = equal_in;
            cfg_d.len        = clamp_len(len_in);
            cfg_d.div        = clamp_div(div_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode       <= MODE_STATIC;
            cfg_q.equal_rate <= 1'b0;
            cfg_q.len        <= ACS_LEN_W'(1);
            cfg_q.div        <= ACS_DIV_W'(ACS_MIN_DIV);
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/acs_pacer.sv
module acs_pacer #(
    parameter int W = acs_pkg::ACS_DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic [W-1:0] gap,
    input  logic         enable,
    output logic         fire
);

    logic [W-1:0] cnt_q;

    assign fire = enable && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= gap - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

endmodule

// File: rtl/acs_se_stage.sv
module acs_se_stage #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic se
);

    always_ff @(posedge clk) begin
        if (rst) begin
            se <= IDLE_LEVEL;
        end else begin
            se <= req;
        end
    end

endmodule

// File: rtl/atspeed_capture_seq.sv
module atspeed_capture_seq
    import acs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           capture_mode,
    input  logic                 equal_rate,
    input  logic [ACS_LEN_W-1:0] chain_len,
    input  logic [ACS_DIV_W-1:0] shift_div,
    input  logic [ACS_PAT_W-1:0] pattern_count,
    output logic                 scan_clk_en,
    output logic                 scan_en,
    output logic                 load_active,
    output logic                 capture_active,
    output logic                 unload_active,
    output logic                 done
);

    acs_state_e              st_q, st_d;
    acs_pulse_e              kind_q, kind_d;
    logic [ACS_LEN_W-1:0]    shift_q, shift_d;
    logic [ACS_PAT_W-1:0]    pat_q, pat_d;
    logic                    seen_cap_q, seen_cap_d;
    logic                    se_req_q, se_req_d;
    acs_flags_t              flags_q, flags_d;
    logic                    pulse_q;
    logic                    done_q, done_d;

    acs_cfg_t                cfg_q;
    logic                    take;
    logic                    fire;
    logic                    arm;
    logic [ACS_DIV_W-1:0]    gap;

    assign take = start && (st_q == ST_IDLE);

    acs_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .mode_in  (capture_mode),
        .equal_in (equal_rate),
        .len_in   (chain_len),
        .div_in   (shift_div),
        .cfg_q    (cfg_q)
    );

    acs_pacer #(.W(ACS_DIV_W)) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .gap    (gap),
        .enable (st_q == ST_RUN),
        .fire   (fire)
    );

    acs_se_stage #(.IDLE_LEVEL(1'b1)) u_se (
        .clk (clk),
        .rst (rst),
        .req (se_req_q),
        .se  (scan_en)
    );

    always_comb begin
        st_d       = st_q;
        kind_d     = kind_q;
        shift_d    = shift_q;
        pat_d      = pat_q;
        seen_cap_d = seen_cap_q;
        se_req_d   = se_req_q;
        flags_d    = flags_q;
        done_d     = 1'b0;
        arm        = 1'b0;
        gap        = cfg_q.div;

        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d       = ST_RUN;
                    kind_d     = PULSE_SHIFT;
                    shift_d    = clamp_len(chain_len);
                    pat_d      = clamp_pats(pattern_count);
                    seen_cap_d = 1'b0;
                    se_req_d   = 1'b1;
                    arm        = 1'b1;
                    gap        = clamp_div(shift_div);
                end
            end

            ST_RUN: begin
                if (fire) begin
                    arm = 1'b1;
                    unique case (kind_q)
                        PULSE_SHIFT: begin
                            flags_d.load    = (pat_q != '0);
                            flags_d.unload  = seen_cap_q;
                            flags_d.capture = 1'b0;
                            shift_d         = shift_q - ACS_LEN_W'(1);
                            if (shift_q == ACS_LEN_W'(1)) begin
                                if (pat_q == '0) begin
                                    st_d = ST_DONE;
                                end else begin
                                    kind_d   = PULSE_CAP_FIRST;
                                    se_req_d = 1'b0;
                                    gap      = fast_launch(cfg_q) ? ACS_DIV_W'(1) : cfg_q.div;
                                end
                            end
                        end
                        PULSE_CAP_FIRST: begin
                            flags_d = '{load: 1'b0, capture: 1'b1, unload: 1'b0};
                            if (two_captures(cfg_q)) begin
                                kind_d = PULSE_CAP_SECOND;
                                gap    = cfg_q.equal_rate ? cfg_q.div : ACS_DIV_W'(1);
                            end else begin
                                kind_d     = PULSE_SHIFT;
                                pat_d      = pat_q - ACS_PAT_W'(1);
                                shift_d    = cfg_q.len;
                                seen_cap_d = 1'b1;
                                se_req_d   = 1'b1;
                            end
                        end
                        default: begin
                            flags_d    = '{load: 1'b0, capture: 1'b1, unload: 1'b0};
                            kind_d     = PULSE_SHIFT;
                            pat_d      = pat_q - ACS_PAT_W'(1);
                            shift_d    = cfg_q.len;
                            seen_cap_d = 1'b1;
                            se_req_d   = 1'b1;
                        end
                    endcase
                end
            end

            default: begin
                st_d     = ST_IDLE;
                done_d   = 1'b1;
                flags_d  = '0;
                se_req_d = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            kind_q     <= PULSE_SHIFT;
            shift_q    <= '0;
            pat_q      <= '0;
            seen_cap_q <= 1'b0;
            se_req_q   <= 1'b1;
            flags_q    <= '0;
            pulse_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            st_q       <= st_d;
            kind_q     <= kind_d;
            shift_q    <= shift_d;
            pat_q      <= pat_d;
            seen_cap_q <= seen_cap_d;
            se_req_q   <= se_req_d;
            flags_q    <= flags_d;
            pulse_q    <= fire;
            done_q     <= done_d;
        end
    end

    assign scan_clk_en    = pulse_q;
    assign load_active    = flags_q.load;
    assign capture_active = flags_q.capture;
    assign unload_active  = flags_q.unload;
    assign done           = done_q;

endmodule

// File: rtl/acs_checker.sv
module acs_checker (
    input logic clk,
    input logic rst,
    input logic scan_clk_en,
    input logic scan_en,
    input logic load_active,
    input logic capture_active,
    input logic unload_active,
    input logic done
);

    AST_SE_HIGH_AT_SHIFT: assert property (@(posedge clk) disable iff (rst)
        scan_clk_en && (load_active || unload_active) |-> scan_en); // R7

    AST_SE_LOW_AT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        scan_clk_en && capture_active |-> !scan_en); // R7

    AST_ONE_PULSE_KIND: assert property (@(posedge clk) disable iff (rst)
        scan_clk_en |-> $countones({capture_active, load_active || unload_active}) == 1); // R9

    AST_PAIR_ENDS_IN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        scan_clk_en && $past(scan_clk_en) |-> capture_active); // R3

    AST_NO_THIRD_FAST: assert property (@(posedge clk) disable iff (rst)
        scan_clk_en && $past(scan_clk_en) |=> !scan_clk_en); // R3

    AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(scan_clk_en) && !scan_clk_en); // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        done |-> !(load_active || capture_active || unload_active) && scan_en); // R10

endmodule

bind atspeed_capture_seq acs_checker u_acs_checker (
    .clk            (clk),
    .rst            (rst),
    .scan_clk_en    (scan_clk_en),
    .scan_en        (scan_en),
    .load_active    (load_active),
    .capture_active (capture_active),
    .unload_active  (unload_active),
    .done           (done)
);

// File: tb/test_atspeed_capture_seq.sv
module test_atspeed_capture_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  capture_mode = 2'b00;
    logic        equal_rate = 1'b0;
    logic [15:0] chain_len = 16'd1;
    logic [7:0]  shift_div = 8'd2;
    logic [15:0] pattern_count = 16'd1;
    logic        scan_clk_en, scan_en, load_active, capture_active, unload_active, done;

    int checks = 0;
    int failures = 0;

    atspeed_capture_seq i_atspeed_capture_seq (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .capture_mode   (capture_mode),
        .equal_rate     (equal_rate),
        .chain_len      (chain_len),
        .shift_div      (shift_div),
        .pattern_count  (pattern_count),
        .scan_clk_en    (scan_clk_en),
        .scan_en        (scan_en),
        .load_active    (load_active),
        .capture_active (capture_active),
        .unload_active  (unload_active),
        .done           (done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // expected configuration of the run in progress
    int e_mode, e_byp, e_n, e_div, e_p, e_caps;
    bit active = 1'b0;
    int cyc = 0;
    int pulse_idx, short_cnt, done_seen, last_pulse_cyc;
    int prev_se = 1;
    bit want_se_low = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (active) begin
            if (want_se_low) begin
                check(scan_en == 1'b0, "R7 scan_en after pre-capture shift", scan_en, 0);
                want_se_low = 1'b0;
            end
            if (scan_clk_en) begin
                int k, j, blk, p, r, gexp, sexp, fexp, fact;
                bit is_cap, fin;
                k = pulse_idx;
                is_cap = 1'b0; fin = 1'b0; gexp = e_div; r = 0; p = 0;
                if (k < e_n) begin
                    fexp = 3'b100;
                    fin = (k == e_n - 1);
                end else begin
                    j = k - e_n;
                    blk = e_caps + e_n;
                    p = j / blk;
                    r = j % blk;
                    if (r < e_caps) begin
                        is_cap = 1'b1;
                        fexp = 3'b010;
                        if (r == 0) gexp = (e_mode == 1 && e_byp == 0) ? 1 : e_div;
                        else        gexp = (e_byp != 0) ? e_div : 1;
                    end else begin
                        fexp = (p < e_p - 1) ? 3'b101 : 3'b001;
                        fin = (r == blk - 1) && (p < e_p - 1);
                    end
                end
                if (k < e_n && k == e_n - 1) fin = 1'b1;
                if (k > 0) begin
                    check((cyc - last_pulse_cyc) == gexp, "R3 R4 R5 R6 R8 pulse interval",
                          cyc - last_pulse_cyc, gexp);
                    if (cyc - last_pulse_cyc < e_div) short_cnt++;
                end
                sexp = is_cap ? 0 : 1;
                check(int'(scan_en) == sexp, "R7 scan_en at pulse", scan_en, sexp);
                fact = {load_active, capture_active, unload_active};
                check(fact == fexp, "R9 flags at pulse", fact, fexp);
                if (is_cap && r == 0)
                    check(prev_se == ((e_mode == 1 && e_byp == 0) ? 1 : 0),
                          "R4 R5 R6 scan_en before first capture", prev_se,
                          (e_mode == 1 && e_byp == 0) ? 1 : 0);
                if (is_cap && r == 1)
                    check(prev_se == 0, "R5 scan_en before second capture", prev_se, 0);
                if (fin) want_se_low = 1'b1;
                if (is_cap && r == e_caps - 1) begin
                    // R7: scan_en back to 1 in the next cycle, checked via prev_se path below
                end
                pulse_idx++;
                last_pulse_cyc = cyc;
            end else if (pulse_idx > e_n && ((pulse_idx - e_n - 1) % (e_caps + e_n)) == e_caps - 1
                         && (cyc - last_pulse_cyc) == 1) begin
                check(scan_en == 1'b1, "R7 scan_en restored after capture", scan_en, 1);
            end
            if (done) begin
                done_seen++;
                check((cyc - last_pulse_cyc) == 1, "R10 done one cycle after last pulse",
                      cyc - last_pulse_cyc, 1);
                check(pulse_idx == e_n + e_p * (e_caps + e_n), "R2 total pulses",
                      pulse_idx, e_n + e_p * (e_caps + e_n));
                check({load_active, capture_active, unload_active} == 3'b000 && scan_en,
                      "R10 flags clear at done", {load_active, capture_active, unload_active}, 0);
            end
        end
        prev_se = scan_en;
    end

    task automatic run_case(input int mode, input int byp, input int n, input int dv,
                            input int p, input bit poke);
        e_mode = mode;
        e_byp  = byp;
        e_n    = (n == 0) ? 1 : n;
        e_div  = (dv < 2) ? 2 : dv;
        e_p    = (p == 0) ? 1 : p;
        e_caps = (mode == 2) ? 2 : 1;
        pulse_idx = 0; short_cnt = 0; done_seen = 0; last_pulse_cyc = 0;
        want_se_low = 1'b0;
        @(negedge clk);
        capture_mode  = 2'(mode);
        equal_rate    = 1'(byp);
        chain_len     = 16'(n);
        shift_div     = 8'(dv);
        pattern_count = 16'(p);
        start = 1'b1;
        active = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: new settings and a second start while running
            capture_mode  = 2'(3 - mode);
            equal_rate    = ~equal_rate;
            chain_len     = 16'(n + 5);
            shift_div     = 8'(dv + 3);
            pattern_count = 16'(p + 2);
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_seen == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(done_seen == 1, "R10 R11 done pulse count", done_seen, 1);
        check(short_cnt == ((mode == 1 || mode == 2) && byp == 0 ? e_p : 0),
              "R3 R6 R8 at-speed interval count", short_cnt,
              (mode == 1 || mode == 2) && byp == 0 ? e_p : 0);
        check(pulse_idx == e_n + e_p * (e_caps + e_n), "R2 R11 pulses in run",
              pulse_idx, e_n + e_p * (e_caps + e_n));
        active = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(scan_clk_en == 1'b0 && done == 1'b0, "R1 pulse and done in reset",
              {scan_clk_en, done}, 0);
        check(scan_en == 1'b1, "R1 scan_en in reset", scan_en, 1);
        check({load_active, capture_active, unload_active} == 3'b000, "R1 flags in reset",
              {load_active, capture_active, unload_active}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(scan_clk_en == 1'b0 && done == 1'b0 && scan_en == 1'b1, "R1 idle after reset",
              {scan_clk_en, done, scan_en}, 1);

        for (int m = 0; m < 4; m++)
            for (int b = 0; b < 2; b++)
                for (int n = 1; n <= 3; n += 2)
                    for (int d = 2; d <= 3; d++)
                        for (int p = 1; p <= 2; p++)
                            run_case(m, b, n, d, p, 1'b0);

        run_case(1, 0, 20, 8, 3, 1'b0);   // R4 longer chain at 8:1
        run_case(2, 0, 12, 8, 3, 1'b0);   // R5
        run_case(1, 0, 0, 0, 0, 1'b0);    // R12 all clamps
        run_case(2, 0, 2, 1, 0, 1'b0);    // R12 divider 1
        run_case(0, 0, 0, 4, 2, 1'b0);    // R12 length 0
        run_case(1, 0, 4, 3, 2, 1'b1);    // R11 start during run
        run_case(2, 1, 3, 4, 2, 1'b1);    // R11 R8

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule